// File: doc/BRIEF.md
# Console Run, Stop and Step Controller

This block decides whether the processor is allowed to execute. It takes the operator's console command strobes (start, continue, stop, reset, single-instruction step and single-memory-access step), the 16-bit switch register and completion strobes from the processor. From these it produces the run enable that gates the processor, a program counter load strobe with its value, one-cycle reset pulses for the I/O bus and the memory bus, and the console status lamps.

A stop request does not halt at once. It is held as pending until the current instruction finishes, and a continue that arrives first withdraws it. Reset acts in the next cycle and wins over every other command. Start loads the program counter from the switches and pulses the I/O bus reset in one launch cycle, and execution begins in the following cycle. The two step commands run the processor until the next instruction completes or until the next memory access completes.

Top module: `console_run_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every output is low (`pc_value` is zero).
- R2: A start granted while idle makes the next cycle a launch cycle (`pc_load`=1, `pc_value`=switches, `io_reset`=1, `mem_reset`=0, `run_en`=0). `run_en` rises in the cycle after that. Stop and continue are ignored during the launch cycle.
- R3: A stop while running is held as pending. `run_en` falls in the cycle after `ev_inst_done`, including a completion in the same cycle as the stop.
- R4: A continue while running clears a pending stop. This includes a continue in the cycle of completion, and a stop and continue given together leave no stop pending.
- R5: `cmd_reset` has the highest priority. In the next cycle `run_en`=0 and `io_reset`=`mem_reset`=1, each for one cycle only. The reset also drops any pending stop and any step mode.
- R6: A continue while idle sets `run_en` in the next cycle, with no `pc_load` and no bus reset.
- R7: While running, `ev_halt` together with `ev_inst_done` clears `run_en` in the next cycle. `lamp_ion` is not affected.
- R8: An instruction step while idle sets `run_en` in the next cycle and clears it in the cycle after the first `ev_inst_done`. `ev_mem_done` does not end it.
- R9: A memory step while idle sets `run_en` in the next cycle and clears it in the cycle after the first `ev_mem_done`.
- R10: Start and both step commands have no effect while running: no `pc_load`, no bus reset, and the run mode is unchanged.
- R11: `lamp_run` equals `run_en`. `lamp_ion` shows `ion_in` one cycle later. `lamp_fetch`, `lamp_defer` and `lamp_exec` show `time_state` codes 1, 2 and 3 one cycle later; code 0 lights none of them.
- R12: When idle, the commands rank start, then instruction step, then memory step, then continue. Completion and halt strobes are ignored while `run_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_value | input | 16 | Console switch register |
| cmd_start | input | 1 | Start strobe |
| cmd_continue | input | 1 | Continue strobe |
| cmd_stop | input | 1 | Stop strobe |
| cmd_reset | input | 1 | Console reset strobe |
| cmd_istep | input | 1 | Instruction step strobe |
| cmd_mstep | input | 1 | Memory step strobe |
| ev_inst_done | input | 1 | Processor finished an instruction |
| ev_mem_done | input | 1 | Processor finished a memory access |
| ev_halt | input | 1 | Finishing instruction was a halt |
| ion_in | input | 1 | Interrupt enable state from the processor |
| time_state | input | 2 | 0 none, 1 fetch, 2 defer, 3 execute |
| run_en | output | 1 | Processor may execute |
| pc_load | output | 1 | Load program counter strobe |
| pc_value | output | 16 | Value for the program counter |
| io_reset | output | 1 | I/O bus reset pulse |
| mem_reset | output | 1 | Memory bus reset pulse |
| lamp_run | output | 1 | RUN lamp |
| lamp_ion | output | 1 | Interrupts-enabled lamp |
| lamp_fetch | output | 1 | Fetch time-state lamp |
| lamp_defer | output | 1 | Indirect-address time-state lamp |
| lamp_exec | output | 1 | Execute time-state lamp |

## Verification
Directed sequences first separate a stop that completes from one withdrawn by continue, and check the case where continue and completion arrive in the same cycle. They also separate the two step modes by giving each the other mode's completion strobe before its own. Another group gives reset together with start and continue while a stop is pending, so the test shows both that reset has priority and that the pending stop is cleared. A long run of seeded random strobes then mixes commands with completion events in both the running and the idle state. This reaches overlaps such as start with a step, and a halt with a pending stop.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_INST = 2'd1,
    STEP_MEM  = 2'd2
  } step_e;

  typedef struct packed {
    logic do_reset;
    logic do_start;
    logic do_istep;
    logic do_mstep;
    logic do_resume;
    logic req_stop;
    logic req_cancel;
  } grant_t;
endpackage

// File: rtl/rsc_cmd_arb.sv
module rsc_cmd_arb
  import rsc_pkg::*;
(
  input  logic   running,
  input  logic   launching,
  input  logic   cmd_start,
  input  logic   cmd_continue,
  input  logic   cmd_stop,
  input  logic   cmd_reset,
  input  logic   cmd_istep,
  input  logic   cmd_mstep,
  output grant_t grant
);
  logic idle;
  assign idle = !running && !launching;

  always_comb begin
    grant = '0;
    if (cmd_reset) begin
      grant.do_reset = 1'b1;
    end else if (idle) begin
      if (cmd_start)          grant.do_start  = 1'b1;
      else if (cmd_istep)     grant.do_istep  = 1'b1;
      else if (cmd_mstep)     grant.do_mstep  = 1'b1;
      else if (cmd_continue)  grant.do_resume = 1'b1;
    end else if (running) begin
      grant.req_stop   = cmd_stop;
      grant.req_cancel = cmd_continue;
    end
  end
endmodule

// File: rtl/rsc_run_core.sv
module rsc_run_core
  import rsc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  grant_t grant,
  input  logic   ev_inst_done,
  input  logic   ev_mem_done,
  input  logic   ev_halt,
  output logic   running,
  output logic   launching
);
  logic  pend_q;
  step_e mode_q;
  logic  stop_eff;
  logic  end_now;

  assign stop_eff = (pend_q || grant.req_stop) && !grant.req_cancel;
  assign end_now  = (ev_inst_done && (stop_eff || ev_halt || mode_q == STEP_INST))
                 || (ev_mem_done && mode_q == STEP_MEM);

  always_ff @(posedge clk) begin
    if (rst || grant.do_reset) begin
      running   <= 1'b0;
      launching <= 1'b0;
      pend_q    <= 1'b0;
      mode_q    <= STEP_NONE;
    end else if (launching) begin
      launching <= 1'b0;
      running   <= 1'b1;
    end else if (!running) begin
      pend_q <= 1'b0;
      if (grant.do_start) begin
        launching <= 1'b1;
        mode_q    <= STEP_NONE;
      end else if (grant.do_istep) begin
        running <= 1'b1;
        mode_q  <= STEP_INST;
      end else if (grant.do_mstep) begin
        running <= 1'b1;
        mode_q  <= STEP_MEM;
      end else if (grant.do_resume) begin
        running <= 1'b1;
        mode_q  <= STEP_NONE;
      end
    end else if (end_now) begin
      running <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      pend_q <= stop_eff;
    end
  end
endmodule

// File: rtl/rsc_pulse_gen.sv
module rsc_pulse_gen #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              do_reset,
  input  logic              do_start,
  input  logic [DATA_W-1:0] sw_value,
  output logic              pc_load,
  output logic [DATA_W-1:0] pc_value,
  output logic              io_reset,
  output logic              mem_reset
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_load   <= 1'b0;
      pc_value  <= '0;
      io_reset  <= 1'b0;
      mem_reset <= 1'b0;
    end else begin
      pc_load   <= do_start;
      io_reset  <= do_reset || do_start;
      mem_reset <= do_reset;
      if (do_start) pc_value <= sw_value;
    end
  end
endmodule

// File: rtl/rsc_lamps.sv
module rsc_lamps #(
  parameter int TS_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ion_in,
  input  logic [TS_W-1:0] time_state,
  output logic            lamp_ion,
  output logic [3:1]      ts_lamp
);
  localparam int N_TS = 3;

  always_ff @(posedge clk) begin
    if (rst) lamp_ion <= 1'b0;
    else     lamp_ion <= ion_in;
  end

  for (genvar k = 1; k <= N_TS; k++) begin : g_ts
    always_ff @(posedge clk) begin
      if (rst) ts_lamp[k] <= 1'b0;
      else     ts_lamp[k] <= (time_state == TS_W'(k));
    end
  end
endmodule

// File: rtl/console_run_ctrl.sv
module console_run_ctrl
  import rsc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TS_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sw_value,
  input  logic              cmd_start,
  input  logic              cmd_continue,
  input  logic              cmd_stop,
  input  logic              cmd_reset,
  input  logic              cmd_istep,
  input  logic              cmd_mstep,
  input  logic              ev_inst_done,
  input  logic              ev_mem_done,
  input  logic              ev_halt,
  input  logic              ion_in,
  input  logic [TS_W-1:0]   time_state,
  output logic              run_en,
  output logic              pc_load,
  output logic [DATA_W-1:0] pc_value,
  output logic              io_reset,
  output logic              mem_reset,
  output logic              lamp_run,
  output logic              lamp_ion,
  output logic              lamp_fetch,
  output logic              lamp_defer,
  output logic              lamp_exec
);
  grant_t     grant;
  logic       running;
  logic       launching;
  logic [3:1] ts_lamp;

  rsc_cmd_arb u_arb (
    .running      (running),
    .launching    (launching),
    .cmd_start    (cmd_start),
    .cmd_continue (cmd_continue),
    .cmd_stop     (cmd_stop),
    .cmd_reset    (cmd_reset),
    .cmd_istep    (cmd_istep),
    .cmd_mstep    (cmd_mstep),
    .grant        (grant)
  );

  rsc_run_core u_core (
    .clk          (clk),
    .rst          (rst),
    .grant        (grant),
    .ev_inst_done (ev_inst_done),
    .ev_mem_done  (ev_mem_done),
    .ev_halt      (ev_halt),
    .running      (running),
    .launching    (launching)
  );

  rsc_pulse_gen #(.DATA_W(DATA_W)) u_pulse (
    .clk       (clk),
    .rst       (rst),
    .do_reset  (grant.do_reset),
    .do_start  (grant.do_start),
    .sw_value  (sw_value),
    .pc_load   (pc_load),
    .pc_value  (pc_value),
    .io_reset  (io_reset),
    .mem_reset (mem_reset)
  );

  rsc_lamps #(.TS_W(TS_W)) u_lamps (
    .clk        (clk),
    .rst        (rst),
    .ion_in     (ion_in),
    .time_state (time_state),
    .lamp_ion   (lamp_ion),
    .ts_lamp    (ts_lamp)
  );

  assign run_en     = running;
  assign lamp_run   = running;
  assign lamp_fetch = ts_lamp[1];
  assign lamp_defer = ts_lamp[2];
  assign lamp_exec  = ts_lamp[3];
endmodule

// File: rtl/console_run_ctrl_chk.sv
module console_run_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic cmd_start,
  input logic cmd_reset,
  input logic ev_inst_done,
  input logic ev_halt,
  input logic run_en,
  input logic pc_load,
  input logic io_reset,
  input logic mem_reset,
  input logic lamp_run,
  input logic lamp_fetch,
  input logic lamp_defer,
  input logic lamp_exec
);
  p_reset_now_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_reset |=> (io_reset && mem_reset && !run_en));

  p_mem_pulse_src_r5: assert property (@(posedge clk) disable iff (rst)
    mem_reset |-> $past(cmd_reset));

  p_start_launch_r2: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !pc_load && cmd_start && !cmd_reset) |=> (pc_load && io_reset && !run_en));

  p_launch_to_run_r2: assert property (@(posedge clk) disable iff (rst)
    (pc_load && !cmd_reset) |=> run_en);

  p_no_load_running_r10: assert property (@(posedge clk) disable iff (rst)
    run_en |=> !pc_load);

  p_halt_stops_r7: assert property (@(posedge clk) disable iff (rst)
    (run_en && ev_inst_done && ev_halt && !cmd_reset) |=> !run_en);

  p_ts_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lamp_fetch, lamp_defer, lamp_exec}));

  always @(negedge clk) begin
    if (!rst) begin
      p_run_lamp_r11: assert (lamp_run == run_en);
    end
  end
endmodule

bind console_run_ctrl console_run_ctrl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_start    (cmd_start),
  .cmd_reset    (cmd_reset),
  .ev_inst_done (ev_inst_done),
  .ev_halt      (ev_halt),
  .run_en       (run_en),
  .pc_load      (pc_load),
  .io_reset     (io_reset),
  .mem_reset    (mem_reset),
  .lamp_run     (lamp_run),
  .lamp_fetch   (lamp_fetch),
  .lamp_defer   (lamp_defer),
  .lamp_exec    (lamp_exec)
);

// File: tb/console_run_ctrl_test.sv
module console_run_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] sw_value = '0;
  logic        cmd_start = 0, cmd_continue = 0, cmd_stop = 0, cmd_reset = 0;
  logic        cmd_istep = 0, cmd_mstep = 0;
  logic        ev_inst_done = 0, ev_mem_done = 0, ev_halt = 0, ion_in = 0;
  logic [1:0]  time_state = '0;
  logic        run_en, pc_load, io_reset, mem_reset;
  logic [15:0] pc_value;
  logic        lamp_run, lamp_ion, lamp_fetch, lamp_defer, lamp_exec;

  always #(CLK_PERIOD/2) clk = ~clk;

  console_run_ctrl uut (.*);

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // reference state: 0 none, 1 instruction step, 2 memory step
  logic        m_run = 0, m_launch = 0, m_pend = 0;
  int          m_mode = 0;
  logic        e_pcl = 0, e_io = 0, e_mem = 0, e_ion = 0;
  logic [15:0] e_pcv = '0;
  logic [2:0]  e_ts = '0;

  function automatic logic [2:0] ts_decode(input logic [1:0] t);
    return (t == 2'd1) ? 3'b001 : (t == 2'd2) ? 3'b010 : (t == 2'd3) ? 3'b100 : 3'b000;
  endfunction

  task automatic model_step();
    logic stop_eff, end_now;
    e_pcl = 0; e_io = 0; e_mem = 0;
    if (rst) begin
      m_run = 0; m_launch = 0; m_pend = 0; m_mode = 0; e_pcv = '0;
      e_ion = 0; e_ts = '0;
      return;
    end
    e_ion = ion_in;
    e_ts  = ts_decode(time_state);
    if (cmd_reset) begin
      m_run = 0; m_launch = 0; m_pend = 0; m_mode = 0; e_io = 1; e_mem = 1;
    end else if (m_launch) begin
      m_launch = 0; m_run = 1;
    end else if (!m_run) begin
      m_pend = 0;
      if (cmd_start) begin
        m_launch = 1; m_mode = 0; e_pcl = 1; e_io = 1; e_pcv = sw_value;
      end else if (cmd_istep) begin
        m_run = 1; m_mode = 1;
      end else if (cmd_mstep) begin
        m_run = 1; m_mode = 2;
      end else if (cmd_continue) begin
        m_run = 1; m_mode = 0;
      end
    end else begin
      stop_eff = (m_pend || cmd_stop) && !cmd_continue;
      end_now  = (ev_inst_done && (stop_eff || ev_halt || m_mode == 1))
              || (ev_mem_done && m_mode == 2);
      if (end_now) begin
        m_run = 0; m_pend = 0;
      end else begin
        m_pend = stop_eff;
      end
    end
  endtask

  task automatic compare();
    logic [2:0] got_ts;
    got_ts = {lamp_exec, lamp_defer, lamp_fetch};
    checks++;
    if (run_en !== m_run || lamp_run !== m_run || pc_load !== e_pcl ||
        io_reset !== e_io || mem_reset !== e_mem || lamp_ion !== e_ion ||
        got_ts !== e_ts || (e_pcl && pc_value !== e_pcv)) begin
      errors++;
      $display("FAIL %s: got run=%b pcl=%b pcv=%h io=%b mem=%b ion=%b ts=%b exp run=%b pcl=%b pcv=%h io=%b mem=%b ion=%b ts=%b",
               cur_req, run_en, pc_load, pc_value, io_reset, mem_reset, lamp_ion, got_ts,
               m_run, e_pcl, e_pcv, e_io, e_mem, e_ion, e_ts);
    end
  endtask

  task automatic clear_in();
    cmd_start = 0; cmd_continue = 0; cmd_stop = 0; cmd_reset = 0;
    cmd_istep = 0; cmd_mstep = 0; ev_inst_done = 0; ev_mem_done = 0; ev_halt = 0;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    clear_in();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd5117));
    @(negedge clk);
    // R1: reset state
    cur_req = "R1"; rst = 1; idle(3);
    rst = 0; tick();

    // R2: start, launch cycle, then run
    cur_req = "R2"; sw_value = 16'hA5C3; cmd_start = 1; tick();
    cmd_stop = 1; tick();            // stop ignored in launch cycle
    idle(2);

    // R10: start and steps ignored while running
    cur_req = "R10"; sw_value = 16'h1111; cmd_start = 1; tick();
    cmd_istep = 1; tick();
    ev_inst_done = 1; tick();        // still free-running
    ev_mem_done = 1; tick();

    // R3: pending stop ends at completion
    cur_req = "R3"; cmd_stop = 1; tick();
    idle(2);
    ev_inst_done = 1; tick();
    idle(1);

    // R6: continue while idle
    cur_req = "R6"; cmd_continue = 1; tick();
    idle(1);

    // R4: continue withdraws stop
    cur_req = "R4"; cmd_stop = 1; tick();
    cmd_continue = 1; tick();
    ev_inst_done = 1; tick();
    cmd_stop = 1; tick();
    cmd_continue = 1; ev_inst_done = 1; tick();
    cmd_stop = 1; cmd_continue = 1; tick();
    ev_inst_done = 1; tick();

    // R3: stop in the same cycle as completion
    cur_req = "R3"; cmd_stop = 1; ev_inst_done = 1; tick();
    cmd_continue = 1; tick();

    // R7: halt with ion held high
    cur_req = "R7"; ion_in = 1; tick();
    ev_halt = 1; ev_inst_done = 1; tick();
    idle(2);
    ion_in = 0; tick();

    // R5: reset beats start/continue and clears a pending stop
    cur_req = "R5"; cmd_continue = 1; tick();
    cmd_stop = 1; tick();
    cmd_reset = 1; cmd_start = 1; cmd_continue = 1; tick();
    idle(2);
    cmd_continue = 1; tick();
    ev_inst_done = 1; tick();        // no stop left pending
    cmd_reset = 1; tick();
    cmd_reset = 1; tick();

    // R8: instruction step
    cur_req = "R8"; cmd_istep = 1; tick();
    ev_mem_done = 1; tick();
    ev_inst_done = 1; tick();
    idle(1);

    // R9: memory step
    cur_req = "R9"; cmd_mstep = 1; tick();
    ev_inst_done = 1; tick();
    ev_mem_done = 1; tick();

    // R12: idle priority and ignored events
    cur_req = "R12"; ev_inst_done = 1; ev_halt = 1; ev_mem_done = 1; tick();
    sw_value = 16'h0F0F; cmd_start = 1; cmd_istep = 1; cmd_continue = 1; tick();
    idle(1);
    cmd_reset = 1; tick();
    cmd_istep = 1; cmd_mstep = 1; cmd_continue = 1; tick();
    ev_mem_done = 1; tick();
    ev_inst_done = 1; tick();
    cmd_mstep = 1; cmd_continue = 1; tick();
    ev_mem_done = 1; tick();

    // R11: lamp decode across all time-state codes
    cur_req = "R11";
    for (int t = 0; t < 4; t++) begin
      time_state = 2'(t); ion_in = t[0]; tick();
    end

    // R12: seeded random mix
    cur_req = "R12";
    for (int i = 0; i < 4000; i++) begin
      sw_value     = 16'($urandom);
      time_state   = 2'($urandom);
      ion_in       = 1'($urandom);
      cmd_start    = ($urandom % 12) == 0;
      cmd_continue = ($urandom % 10) == 0;
      cmd_stop     = ($urandom % 10) == 0;
      cmd_reset    = ($urandom % 60) == 0;
      cmd_istep    = ($urandom % 12) == 0;
      cmd_mstep    = ($urandom % 12) == 0;
      ev_inst_done = ($urandom % 4) == 0;
      ev_mem_done  = ($urandom % 3) == 0;
      ev_halt      = ($urandom % 8) == 0;
      tick();
    end
    finish_run();
  end
endmodule